// File: doc/BRIEF.md
# Three-Channel Interval Timer

This block holds three independent 16-bit down counters that are programmed over a small byte-wide register port. A control word picks one channel and sets how its count is written (low byte only, high byte only, or low byte then high byte) and which operating mode it uses. The count is then written through that channel's own counter port. Counting advances only on cycles where the `tick_i` strobe is high. Each tick lowers the count by a fixed step, and the count never goes below zero.

Two modes count. In the one-shot terminal mode, the channel output rises when the count reaches zero, and the channel then stops. In the square-wave mode, the output toggles and the count reloads every time it runs out. The other mode codes can be programmed, but they hold the count and leave the output low.

Channel 0's output drives an interrupt request, which pulses for one cycle on every rising edge. A separate status port holds four writable bits. When it is read, bit 5 shows channel 2's output.

Each channel runs a three-state machine:
- `CH_NULL` means no valid count, and the channel does not count.
- `CH_HALF` means the low byte of a two-byte load has arrived and the high byte is awaited.
- `CH_COUNT` means the channel is running.

Its transitions are:
- *program*: a control write moves the channel from any state to `CH_NULL`.
- *low byte*: the first write of a two-byte load moves `CH_NULL` or `CH_COUNT` to `CH_HALF`.
- *arm*: a completed load moves the channel to `CH_COUNT`.
- *terminal*: in the terminal mode, reaching zero moves `CH_COUNT` back to `CH_NULL`.
- *reload*: in the square-wave mode, running out keeps the channel in `CH_COUNT` with the count refilled.

Top module: `interval_timer3`

## Requirements
- R1: After reset every channel output is low, `irq0_o` is low, every channel is in `CH_NULL` and ignores ticks, and the status port (address 4) reads 0x00.
- R2: A write to address 3 is a control word. Bits 7:6 select the channel (0 to 2), bits 5:4 select the access (1 = low byte only, 2 = high byte only, 3 = low then high), and bits 3:1 select the mode. Such a write drives the selected channel's output low and puts the channel in `CH_NULL`. A control word with access 0 (0x00 included) or with channel field 3 changes no channel.
- R3: Before a channel has received a control word, writes to its counter port are ignored. Reads of the counter ports (addresses 0 to 2), of the control port and of unused addresses (5 to 7) return 0x00.
- R4: With low-only access, a counter write loads {0x00, data}. With high-only access, it loads {data, 0x00}. With low-then-high access, the first write stores the low byte and the channel stops counting, and the second write loads {second, first}. Every load clears the output, saves the value for reloading, and enters `CH_COUNT`.
- R5: With low-then-high access, a load of two zero bytes gives a count of 65536.
- R6: In mode 0, each tick subtracts TICK_STEP (default 1) with saturation at zero. When the count reaches zero, the output goes high and the channel returns to `CH_NULL`, so a loaded count N raises the output on tick N.
- R7: In mode 3, each tick subtracts the step. If the result is zero, the output toggles and the saved count is restored. The step is then subtracted a second time. With a count of 4, the output first rises on tick 3 and then toggles every 2 ticks. With a count of 2, it rises on tick 2 and then toggles on every tick.
- R8: In any mode other than 0 and 3, a loaded channel holds its count and keeps its output low.
- R9: `irq0_o` is high for exactly one cycle, the first cycle in which channel 0's output is high after being low.
- R10: A write to the status port (address 4) changes only its bits 3:0. A read returns the stored bits with bit 5 replaced by channel 2's output, and bits 7:6 and 4 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Count strobe, one step per high cycle |
| wr_en_i | input | 1 | Write strobe for the register port |
| addr_i | input | 3 | Register address (0-2 counters, 3 control, 4 status) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| out_o | output | 3 | Channel output levels, bit n for channel n |
| irq0_o | output | 1 | One-cycle interrupt request from channel 0 |

## Verification
The in-RTL assertions check on every cycle that:
- a channel outside `CH_COUNT` holds both its count and its output;
- a rising output in mode 0 coincides with the channel returning to `CH_NULL`;
- the other modes never move the count or raise the output;
- the interrupt lasts one cycle and follows every rise of channel 0;
- the read-only status bits never change.

Only the bench scenarios show the exact tick on which an output rises or toggles, the byte order of the loads, the 65536 wrap for a zero count, the control words that are ignored, and the channel 2 mirror in the status port.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int NUM_CH = 3;
    localparam int CNT_W  = 16;
    localparam logic [2:0] ADDR_CTL  = 3'd3;
    localparam logic [2:0] ADDR_MISC = 3'd4;

    typedef enum logic [1:0] {
        CH_NULL  = 2'd0,
        CH_HALF  = 2'd1,
        CH_COUNT = 2'd2
    } ch_state_e;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_LO   = 2'd1,
        ACC_HI   = 2'd2,
        ACC_LOHI = 2'd3
    } acc_e;

    localparam logic [2:0] OPM_TERM   = 3'd0;
    localparam logic [2:0] OPM_SQUARE = 3'd3;
endpackage

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int TICK_STEP = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       ctl_we_i,
    input  logic [1:0] acc_i,
    input  logic [2:0] opm_i,
    input  logic       cnt_we_i,
    input  logic [7:0] data_i,
    output logic       out_o
);
    localparam int VAL_W = CNT_W + 1;
    localparam logic [VAL_W-1:0] STEP_V = VAL_W'(TICK_STEP);
    localparam logic [VAL_W-1:0] FULL_V = VAL_W'(1) << CNT_W;

    ch_state_e        st_q, st_d;
    acc_e             acc_q, acc_d;
    logic [2:0]       opm_q, opm_d;
    logic [VAL_W-1:0] cnt_q, cnt_d, rld_q, rld_d;
    logic [7:0]       lo_q, lo_d;
    logic             out_q, out_d;
    logic             ld;
    logic [VAL_W-1:0] ld_val, step_a;

    function automatic logic [VAL_W-1:0] sat_dec(input logic [VAL_W-1:0] v);
        return (v < STEP_V) ? '0 : v - STEP_V;
    endfunction

    // next-state and output process
    always_comb begin
        st_d   = st_q;
        acc_d  = acc_q;
        opm_d  = opm_q;
        cnt_d  = cnt_q;
        rld_d  = rld_q;
        lo_d   = lo_q;
        out_d  = out_q;
        ld     = 1'b0;
        ld_val = '0;
        step_a = '0;
        if (ctl_we_i) begin
            // program: any state -> CH_NULL
            acc_d = acc_e'(acc_i);
            opm_d = opm_i;
            st_d  = CH_NULL;
            out_d = 1'b0;
        end else if (cnt_we_i) begin
            unique case (acc_q)
                ACC_LO: begin
                    ld     = 1'b1;
                    ld_val = {9'd0, data_i};
                end
                ACC_HI: begin
                    ld     = 1'b1;
                    ld_val = {1'b0, data_i, 8'h00};
                end
                ACC_LOHI: begin
                    if (st_q == CH_HALF) begin
                        ld     = 1'b1;
                        ld_val = ({data_i, lo_q} == 16'h0000) ? FULL_V
                                                              : {1'b0, data_i, lo_q};
                    end else begin
                        // low byte: -> CH_HALF
                        lo_d = data_i;
                        st_d = CH_HALF;
                    end
                end
                ACC_NONE: ;
            endcase
            if (ld) begin
                // arm: -> CH_COUNT
                cnt_d = ld_val;
                rld_d = ld_val;
                st_d  = CH_COUNT;
                out_d = 1'b0;
            end
        end else if (tick_i && st_q == CH_COUNT) begin
            unique case (opm_q)
                OPM_TERM: begin
                    step_a = sat_dec(cnt_q);
                    cnt_d  = step_a;
                    if (step_a == '0) begin
                        // terminal: -> CH_NULL
                        out_d = 1'b1;
                        st_d  = CH_NULL;
                    end
                end
                OPM_SQUARE: begin
                    step_a = sat_dec(cnt_q);
                    if (step_a == '0) begin
                        // reload: stays in CH_COUNT
                        out_d  = ~out_q;
                        step_a = rld_q;
                    end
                    cnt_d = sat_dec(step_a);
                end
                default: ;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= CH_NULL;
            acc_q <= ACC_NONE;
            opm_q <= OPM_TERM;
            cnt_q <= '0;
            rld_q <= '0;
            lo_q  <= '0;
            out_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            acc_q <= acc_d;
            opm_q <= opm_d;
            cnt_q <= cnt_d;
            rld_q <= rld_d;
            lo_q  <= lo_d;
            out_q <= out_d;
        end
    end

    assign out_o = out_q;

    // R2
    null_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != CH_COUNT && !cnt_we_i && !ctl_we_i) |=> ($stable(cnt_q) && $stable(out_q)));

    // R6
    term_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(out_q) && opm_q == OPM_TERM) |-> (st_q == CH_NULL));

    // R8
    other_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_COUNT && opm_q != OPM_TERM && opm_q != OPM_SQUARE && !cnt_we_i && !ctl_we_i)
        |=> ($stable(cnt_q) && !out_q));
endmodule

// File: rtl/tmr_misc_port.sv
module tmr_misc_port (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we_i,
    input  logic [3:0] wdata_i,
    input  logic       ch2_out_i,
    output logic [7:0] rdata_o
);
    logic [7:0] misc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) misc_q <= 8'h00;
        else if (we_i) misc_q <= {misc_q[7:4], wdata_i};
    end

    assign rdata_o = {misc_q[7:6], ch2_out_i, misc_q[4:0]};

    // R10
    misc_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(misc_q[7:4]));
endmodule

// File: rtl/tmr_edge_pulse.sv
module tmr_edge_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic pulse_o
);
    logic lvl_q;

    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl_i;
    end

    assign pulse_o = lvl_i & ~lvl_q;

    // R9
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);

    // R9
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lvl_i) |-> pulse_o);
endmodule

// File: rtl/interval_timer3.sv
module interval_timer3
    import tmr_pkg::*;
#(
    parameter int TICK_STEP = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       wr_en_i,
    input  logic [2:0] addr_i,
    input  logic [7:0] wdata_i,
    output logic [7:0] rdata_o,
    output logic [2:0] out_o,
    output logic       irq0_o
);
    logic       ctl_ok;
    logic [7:0] misc_rdata;

    // a control word with channel field 3 or access 0 touches nothing
    assign ctl_ok = wr_en_i && (addr_i == ADDR_CTL)
                 && (wdata_i[7:6] != 2'b11) && (wdata_i[5:4] != 2'b00);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        tmr_channel #(.TICK_STEP(TICK_STEP)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_i   (tick_i),
            .ctl_we_i (ctl_ok && (wdata_i[7:6] == 2'(g))),
            .acc_i    (wdata_i[5:4]),
            .opm_i    (wdata_i[3:1]),
            .cnt_we_i (wr_en_i && (addr_i == 3'(g))),
            .data_i   (wdata_i),
            .out_o    (out_o[g])
        );
    end

    tmr_misc_port u_misc (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (wr_en_i && (addr_i == ADDR_MISC)),
        .wdata_i   (wdata_i[3:0]),
        .ch2_out_i (out_o[2]),
        .rdata_o   (misc_rdata)
    );

    tmr_edge_pulse u_irq0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl_i   (out_o[0]),
        .pulse_o (irq0_o)
    );

    // counter and control ports read as zero
    always_comb begin
        rdata_o = (addr_i == ADDR_MISC) ? misc_rdata : 8'h00;
    end
endmodule

// File: tb/test_interval_timer3.sv
module test_interval_timer3;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [2:0] addr_i = 3'd4;
    logic [7:0] wdata_i = 8'h00;
    logic [7:0] rdata_o;
    logic [2:0] out_o;
    logic       irq0_o;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done = 1'b0;

    typedef struct {
        string      tag;
        logic [11:0] e;
        logic [11:0] m;
    } sb_t;
    sb_t sb_q[$];

    localparam logic [11:0] M_IRQ = 12'h800;
    localparam logic [11:0] M_O0  = 12'h100;
    localparam logic [11:0] M_O1  = 12'h200;
    localparam logic [11:0] M_O2  = 12'h400;
    localparam logic [11:0] M_RD  = 12'h0FF;

    always #5 clk = ~clk;

    interval_timer3 i_interval_timer3 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
        .out_o(out_o), .irq0_o(irq0_o)
    );

    // monitor: compares after the edge that follows each pushed item
    always @(posedge clk) begin
        #3;
        if (sb_q.size() > 0) begin
            sb_t it;
            logic [11:0] obs;
            it  = sb_q.pop_front();
            obs = {irq0_o, out_o, rdata_o};
            n_chk++;
            if ((obs & it.m) !== (it.e & it.m)) begin
                n_err++;
                $display("FAIL %s: actual %h expected %h (mask %h)", it.tag, obs & it.m, it.e & it.m, it.m);
            end
        end
    end

    task automatic cyc(input logic w, input logic [2:0] a, input logic [7:0] d, input logic t);
        @(negedge clk);
        wr_en_i = w; addr_i = a; wdata_i = d; tick_i = t;
    endtask

    task automatic chk(input string tag, input logic [11:0] e, input logic [11:0] m);
        sb_q.push_back('{tag, e, m});
    endtask

    task automatic ticks(input int n);
        repeat (n) cyc(1'b0, 3'd4, 8'h00, 1'b1);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        cyc(0, 3'd4, 8'h00, 0);
        chk("R1 reset outputs and status", 12'h000, 12'hFFF);
        ticks(3);
        chk("R1 null channels ignore ticks", 12'h000, 12'hFFF);

        // R3 counter write before programming is ignored
        cyc(1, 3'd0, 8'h05, 0);
        ticks(8);
        chk("R3 unprogrammed ch0 stays idle", 12'h000, M_O0 | M_IRQ);
        cyc(0, 3'd0, 8'h00, 0);
        chk("R3 counter port reads zero", 12'h000, M_RD);
        cyc(0, 3'd3, 8'h00, 0);
        chk("R3 control port reads zero", 12'h000, M_RD);
        cyc(0, 3'd6, 8'h00, 0);
        chk("R3 unused address reads zero", 12'h000, M_RD);

        // R6 mode 0 on ch1, low-only access, count 5
        cyc(1, 3'd3, 8'h50, 0);
        cyc(1, 3'd1, 8'h05, 0);
        for (int n = 1; n <= 5; n++) begin
            cyc(0, 3'd4, 8'h00, 1);
            if (n == 4) chk("R6 ch1 low before terminal", 12'h000, M_O1);
            if (n == 5) chk("R6 ch1 high at terminal", 12'h200, M_O1);
        end
        ticks(3);
        chk("R6 ch1 stays high, status bit5 untouched", 12'h200, M_O1 | M_RD);

        // R9 mode 0 on ch0, count 3
        cyc(1, 3'd3, 8'h10, 0);
        cyc(1, 3'd0, 8'h03, 0);
        for (int n = 1; n <= 3; n++) begin
            cyc(0, 3'd4, 8'h00, 1);
            if (n == 2) chk("R9 no irq before rise", 12'h000, M_IRQ | M_O0);
            if (n == 3) chk("R9 irq with ch0 rise", 12'h900, M_IRQ | M_O0);
        end
        cyc(0, 3'd4, 8'h00, 0);
        chk("R9 irq lasts one cycle", 12'h100, M_IRQ | M_O0);

        // R4 low-then-high: no counting between the two bytes
        cyc(1, 3'd3, 8'hB6, 0);
        cyc(1, 3'd2, 8'h04, 0);
        ticks(6);
        chk("R4 ch2 waits for high byte", 12'h000, M_O2);
        cyc(1, 3'd2, 8'h00, 0);
        // R7 mode 3 count 4: rises tick 3, then toggles every 2 ticks; R10 mirror
        for (int n = 1; n <= 12; n++) begin
            logic e2;
            e2 = (n >= 3) && ((((n - 3) / 2) % 2) == 0);
            cyc(0, 3'd4, 8'h00, 1);
            chk($sformatf("R7 ch2 square tick %0d (R10 bit5)", n),
                {1'b0, e2, 2'b00, 2'b00, e2, 5'b0}, M_O2 | M_RD);
        end

        // R2 control write stops ch2 and clears output; R10 write mask
        cyc(1, 3'd3, 8'hB6, 0);
        ticks(4);
        chk("R2 reprogrammed ch2 low and idle", 12'h000, M_O2);
        cyc(1, 3'd4, 8'hFF, 0);
        cyc(0, 3'd4, 8'h00, 0);
        chk("R10 only bits 3:0 writable", 12'h00F, M_RD);
        cyc(1, 3'd4, 8'hA0, 0);
        cyc(0, 3'd4, 8'h00, 0);
        chk("R10 low bits cleared by write", 12'h000, M_RD);

        // R7/R9 ch0 mode 3 count 2, then ignored control words (R2)
        cyc(1, 3'd3, 8'h16, 0);
        cyc(1, 3'd0, 8'h02, 0);
        for (int n = 1; n <= 8; n++) begin
            logic e0, ei;
            if (n == 5) cyc(1, 3'd3, 8'h00, 0);
            if (n == 7) cyc(1, 3'd3, 8'hF0, 0);
            e0 = (n >= 2) && (n % 2 == 0);
            ei = e0;
            cyc(0, 3'd4, 8'h00, 1);
            chk($sformatf("R7 R9 R2 ch0 square tick %0d", n),
                {ei, 2'b00, e0, 8'h00}, M_IRQ | M_O0);
        end
        cyc(1, 3'd3, 8'h16, 0);
        ticks(3);
        chk("R2 control write stops ch0", 12'h000, M_O0 | M_IRQ);

        // R4 high-only: ch1 mode 0, byte 0x01 gives 256
        cyc(1, 3'd3, 8'h60, 0);
        cyc(1, 3'd1, 8'h01, 0);
        ticks(255);
        chk("R4 high-only not yet at 255", 12'h000, M_O1);
        ticks(1);
        chk("R4 high-only terminal at 256", 12'h200, M_O1);

        // R4 low-then-high order: 0x02 then 0x01 gives 258
        cyc(1, 3'd3, 8'h70, 0);
        cyc(1, 3'd1, 8'h02, 0);
        cyc(1, 3'd1, 8'h01, 0);
        ticks(257);
        chk("R4 two-byte not yet at 257", 12'h000, M_O1);
        ticks(1);
        chk("R4 two-byte terminal at 258", 12'h200, M_O1);

        // R5 zero count means 65536
        cyc(1, 3'd3, 8'h70, 0);
        cyc(1, 3'd1, 8'h00, 0);
        cyc(1, 3'd1, 8'h00, 0);
        ticks(65535);
        chk("R5 zero count not done at 65535", 12'h000, M_O1);
        ticks(1);
        chk("R5 zero count terminal at 65536", 12'h200, M_O1);

        // R8 mode 2 holds, output low
        cyc(1, 3'd3, 8'h54, 0);
        cyc(1, 3'd1, 8'h01, 0);
        ticks(4);
        chk("R8 other mode output stays low", 12'h000, M_O1);

        cyc(0, 3'd4, 8'h00, 0);
        repeat (3) @(posedge clk);
        #4;
        done = 1'b1;
        summary();
        $finish;
    end
endmodule